// File: doc/BRIEF.md
# Glitch-Free Clock Fan-Out Controller

The block drives a group of clock outputs from one reference waveform. Every output has its own enable. The enable either lets the output toggle or parks it in a high-impedance state. One shared rate control moves all outputs together between the full reference frequency and half of it. All pins are asynchronous and pass through synchronizers. A change of an enable or of the rate is then held for one more swap boundary and applied at the next one. A swap boundary is the point where both the full-rate and the half-rate waveforms are low, so no output ever emits a shortened pulse. Two further mode outputs, bypass and high bandwidth, are formed by combining an active-low pin with a register bit. For each of them, a low pin, a cleared bit, or both select the mode.

The logic runs on a core clock `clk` at twice the reference frequency. A two-bit phase counter regenerates the reference internally: the full-rate waveform has a period of 2 core cycles (1 high, 1 low) and the half-rate waveform a period of 4 (2 high, 2 low). Phase 3 ends each 4-cycle frame, and the swap boundary is the edge from phase 3 to phase 0. Tri-state is modelled by a per-output `drive_o` flag next to the clock value. When the flag is low, the pad is meant to float. The register bits are plain inputs that come from an external register file. They are synchronized like the pins and reset to 1, which selects full rate, PLL mode and normal bandwidth.

Top module: `gf_clk_fanout`

## Requirements
- R1: After reset, with all inputs at their defaults (enables 0, pins and register bits 1), every `clk_o` and `drive_o` bit is 0 and `bypass_o` and `hibw_o` are 0. The outputs stay that way until an input changes.
- R2: When `oe_i[i]` rises, `drive_o[i]` rises while `clk_o[i]` is low. The first rising edge of `clk_o[i]` follows between 2 and 6 output periods after the change, with the period taken in the current mode.
- R3: When `oe_i[i]` falls, `clk_o[i]` is held low from the next swap boundary onward. `drive_o[i]` falls between 2 and 6 output periods after the change, never while `clk_o[i]` is or was just high, and `clk_o[i]` is 0 whenever `drive_o[i]` is 0.
- R4: In full-rate mode every high phase of an enabled output lasts 1 core cycle. In half-rate mode it lasts 2 core cycles and every low phase lasts 2.
- R5: Half rate is selected when `div2_pin_n` is 0 or `div2_reg` is 0. A switch in either direction shows its first high phase of the new width within 2 to 6 periods of the new mode, and all enabled outputs switch on the same cycle.
- R6: Rate and enable changes take effect only at the swap boundary. No output rises except together with the shared waveform, and no high phase is any length other than 1 or 2 core cycles.
- R7: `bypass_o` is 1 when `bypass_pin_n` is 0 or `bypass_reg` is 0, and is 0 only when both are 1. It follows within 3 core cycles.
- R8: `hibw_o` is 1 when `hibw_pin_n` is 0 or `hibw_reg` is 0, and is 0 only when both are 1. It follows within 3 core cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the reference frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_i | input | N_OUT | Per-output enable, 1 = toggle, 0 = high impedance |
| div2_pin_n | input | 1 | Active-low half-rate pin |
| div2_reg | input | 1 | Half-rate register bit, 0 selects half rate |
| bypass_pin_n | input | 1 | Active-low bypass pin |
| bypass_reg | input | 1 | Bypass register bit, 0 selects bypass |
| hibw_pin_n | input | 1 | Active-low high-bandwidth pin |
| hibw_reg | input | 1 | High-bandwidth register bit, 0 selects high bandwidth |
| clk_o | output | N_OUT | Clock value of each output |
| drive_o | output | N_OUT | Output driver enable, 0 = high impedance |
| bypass_o | output | 1 | 1 = reference routed straight through, PLL unused |
| hibw_o | output | 1 | 1 = high-bandwidth PLL setting |

## Verification
The mode properties for bypass and bandwidth look up to three cycles back. They therefore assume that every pin and register bit sits at its default (pins and bits 1, enables 0) while reset is applied, and the stimulus holds them there until reset is released. The latency windows assume that each control is held long enough to pass the synchronizer and two swap boundaries. The bench therefore changes one control at a time and waits until the expected event has been matched before it makes the next change. Control edges are always driven on the falling clock edge.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
  // Width of the phase counter that regenerates the reference waveforms.
  localparam int PH_W = 2;
  // Last phase of the 4-cycle frame; the edge after it is the swap boundary.
  localparam logic [PH_W-1:0] PH_SWAP    = 2'd3;
  // Phase after which a parked output stops driving (its low phase is over).
  localparam logic [PH_W-1:0] PH_RELEASE = 2'd1;

  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_HALF = 1'b1
  } rate_e;
endpackage

// File: rtl/gfc_sync.sv
module gfc_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gfc_phase.sv
module gfc_phase
  import gfc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  half_req,
  output logic  sel_o,
  output logic  swap_o,
  output logic  release_o,
  output rate_e rate_o
);
  logic [PH_W-1:0] ph_q, ph_nxt;
  rate_e           pend_q, rate_q, rate_nxt;
  logic            sel_q;
  logic            swap, rel;

  assign swap     = (ph_q == PH_SWAP);
  assign rel      = (ph_q == PH_RELEASE);
  assign ph_nxt   = ph_q + 1'b1;
  assign rate_nxt = swap ? pend_q : rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      pend_q <= RATE_FULL;
      rate_q <= RATE_FULL;
      sel_q  <= 1'b0;
    end else begin
      ph_q <= ph_nxt;
      if (swap) begin
        pend_q <= half_req ? RATE_HALF : RATE_FULL;
        rate_q <= pend_q;
      end
      // Registered shared waveform; phase 0 is low in both rates.
      sel_q <= (rate_nxt == RATE_HALF) ? ph_nxt[1] : ph_nxt[0];
    end
  end

  assign sel_o     = sel_q;
  assign swap_o    = swap;
  assign release_o = rel;
  assign rate_o    = rate_q;
endmodule

// File: rtl/gfc_chan.sv
module gfc_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic swap,
  input  logic release_tick,
  input  logic sel,
  output logic clk_o,
  output logic drive_o
);
  logic pend_q, gate_q, drive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      gate_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      if (swap) begin
        pend_q <= en_req;
        gate_q <= pend_q;
        if (pend_q) drive_q <= 1'b1;
      end else if (release_tick && !gate_q) begin
        drive_q <= 1'b0;
      end
    end
  end

  assign clk_o   = gate_q & sel;
  assign drive_o = drive_q;
endmodule

// File: rtl/gfc_strap.sv
module gfc_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic reg_bit,
  output logic mode_o
);
  logic mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= ~pin_n | ~reg_bit;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/gf_clk_fanout.sv
module gf_clk_fanout
  import gfc_pkg::*;
#(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] oe_i,
  input  logic             div2_pin_n,
  input  logic             div2_reg,
  input  logic             bypass_pin_n,
  input  logic             bypass_reg,
  input  logic             hibw_pin_n,
  input  logic             hibw_reg,
  output logic [N_OUT-1:0] clk_o,
  output logic [N_OUT-1:0] drive_o,
  output logic             bypass_o,
  output logic             hibw_o
);
  localparam int CTRL_W  = 6;
  localparam int I_DIV2P = 0;
  localparam int I_DIV2R = 1;
  localparam int I_BYPP  = 2;
  localparam int I_BYPR  = 3;
  localparam int I_BWP   = 4;
  localparam int I_BWR   = 5;

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic [N_OUT-1:0]  oe_s;
  logic              half_req, sel_w, swap_w, release_w;
  rate_e             half_w;

  assign ctrl_raw = {hibw_reg, hibw_pin_n, bypass_reg, bypass_pin_n, div2_reg, div2_pin_n};

  gfc_sync #(.W(N_OUT), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_oe_sync (
    .clk(clk), .rst_n(rst_n), .d(oe_i), .q(oe_s)
  );

  gfc_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTRL_W{1'b1}})) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s)
  );

  assign half_req = ~ctrl_s[I_DIV2P] | ~ctrl_s[I_DIV2R];

  gfc_phase u_phase (
    .clk(clk), .rst_n(rst_n), .half_req(half_req),
    .sel_o(sel_w), .swap_o(swap_w), .release_o(release_w), .rate_o(half_w)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_chan
    gfc_chan u_chan (
      .clk(clk), .rst_n(rst_n), .en_req(oe_s[i]),
      .swap(swap_w), .release_tick(release_w), .sel(sel_w),
      .clk_o(clk_o[i]), .drive_o(drive_o[i])
    );
  end

  gfc_strap u_bypass (
    .clk(clk), .rst_n(rst_n),
    .pin_n(ctrl_s[I_BYPP]), .reg_bit(ctrl_s[I_BYPR]), .mode_o(bypass_o)
  );

  gfc_strap u_hibw (
    .clk(clk), .rst_n(rst_n),
    .pin_n(ctrl_s[I_BWP]), .reg_bit(ctrl_s[I_BWR]), .mode_o(hibw_o)
  );
endmodule

// File: rtl/gfc_chk.sv
module gfc_chk #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] clk_o,
  input logic [N_OUT-1:0] drive_o,
  input logic             sel,
  input logic             half,
  input logic             bypass_pin_n,
  input logic             bypass_reg,
  input logic             bypass_o,
  input logic             hibw_pin_n,
  input logic             hibw_reg,
  input logic             hibw_o
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_ch
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_o[i]) |-> !clk_o[i]);
    p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_o[i] |-> !clk_o[i]);
    p_drop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_o[i]) |-> (!clk_o[i] && !$past(clk_o[i])));
    p_no_runt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_o[i]) |-> $rose(sel));
  end

  p_full_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sel) && !half) |=> !sel);
  p_half_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sel) && half) |=> sel);
  p_swap_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(half) |-> !sel);

  p_bypass_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bypass_pin_n && bypass_reg) && !$past(bypass_pin_n && bypass_reg)
     && !$past(bypass_pin_n && bypass_reg, 2) && !$past(bypass_pin_n && bypass_reg, 3))
    |-> bypass_o);
  p_bypass_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((bypass_pin_n && bypass_reg) && $past(bypass_pin_n && bypass_reg)
     && $past(bypass_pin_n && bypass_reg, 2) && $past(bypass_pin_n && bypass_reg, 3))
    |-> !bypass_o);
  p_hibw_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(hibw_pin_n && hibw_reg) && !$past(hibw_pin_n && hibw_reg)
     && !$past(hibw_pin_n && hibw_reg, 2) && !$past(hibw_pin_n && hibw_reg, 3))
    |-> hibw_o);
  p_hibw_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((hibw_pin_n && hibw_reg) && $past(hibw_pin_n && hibw_reg)
     && $past(hibw_pin_n && hibw_reg, 2) && $past(hibw_pin_n && hibw_reg, 3))
    |-> !hibw_o);
endmodule

bind gf_clk_fanout gfc_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_o(clk_o), .drive_o(drive_o),
  .sel(sel_w), .half(half_w),
  .bypass_pin_n(bypass_pin_n), .bypass_reg(bypass_reg), .bypass_o(bypass_o),
  .hibw_pin_n(hibw_pin_n), .hibw_reg(hibw_reg), .hibw_o(hibw_o)
);

// File: tb/sim_gf_clk_fanout.sv
`timescale 1ns/1ps
module sim_gf_clk_fanout;
  localparam int N = 4;
  localparam int K_ON = 0, K_OFF = 1, K_FULL = 2, K_HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] oe_i = '0;
  logic div2_pin_n = 1'b1, div2_reg = 1'b1;
  logic bypass_pin_n = 1'b1, bypass_reg = 1'b1;
  logic hibw_pin_n = 1'b1, hibw_reg = 1'b1;
  logic [N-1:0] clk_o, drive_o;
  logic bypass_o, hibw_o;

  gf_clk_fanout #(.N_OUT(N)) u0 (
    .clk(clk), .rst_n(rst_n), .oe_i(oe_i),
    .div2_pin_n(div2_pin_n), .div2_reg(div2_reg),
    .bypass_pin_n(bypass_pin_n), .bypass_reg(bypass_reg),
    .hibw_pin_n(hibw_pin_n), .hibw_reg(hibw_reg),
    .clk_o(clk_o), .drive_o(drive_o), .bypass_o(bypass_o), .hibw_o(hibw_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    string tag;
    int    kind;
    int    ch;
    int    start;
    int    lo;
    int    hi;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0;
  int cyc = 0;
  int bad_phase = 0, bad_off = 0, bad_sync = 0;
  bit chk_together = 0;
  bit cur_half = 0;
  bit done = 0;
  logic [N-1:0] prv_o, prv_d;
  int hi_len [N];
  int rise_c [N];

  always @(posedge clk) cyc++;

  task automatic check_eq(string req, int act, int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic check_rng(string req, int act, int lo, int hi);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic note_event(int k, int c, int t);
    if (q.size() > 0 && q[0].kind == k && q[0].ch == c && t > q[0].start) begin
      check_rng(q[0].tag, t - q[0].start, q[0].lo, q[0].hi);
      void'(q.pop_front());
    end
  endtask

  // Monitor: derives events from the ports and matches them to the queue.
  always @(negedge clk) begin
    if (!rst_n) begin
      prv_o = '0;
      prv_d = '0;
      for (int c = 0; c < N; c++) begin hi_len[c] = 0; rise_c[c] = 0; end
    end else begin
      for (int c = 0; c < N; c++) begin
        if (!drive_o[c] && clk_o[c]) bad_off++;
        if (clk_o[c] && !prv_o[c]) begin
          rise_c[c] = cyc;
          hi_len[c] = 1;
          if (drive_o[c]) note_event(K_ON, c, cyc);
        end else if (clk_o[c]) begin
          hi_len[c]++;
        end else if (prv_o[c]) begin
          if (hi_len[c] == 1) note_event(K_FULL, c, rise_c[c]);
          else if (hi_len[c] == 2) note_event(K_HALF, c, rise_c[c]);
          else bad_phase++;
        end
        if (!drive_o[c] && prv_d[c]) note_event(K_OFF, c, cyc);
        if (chk_together && drive_o[c] && drive_o[0] && clk_o[c] != clk_o[0]) bad_sync++;
      end
      prv_o = clk_o;
      prv_d = drive_o;
      if (q.size() > 0 && (cyc - q[0].start) > q[0].hi + 8) begin
        check_rng({q[0].tag, " (no event)"}, cyc - q[0].start, q[0].lo, q[0].hi);
        void'(q.pop_front());
      end
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic push(string tag, int kind, int ch, int per);
    exp_t e;
    e.tag = tag; e.kind = kind; e.ch = ch; e.start = cyc;
    e.lo = 2 * per; e.hi = 6 * per;
    q.push_back(e);
  endtask

  // Driver: change one enable and expect the matching event.
  task automatic set_oe(int c, bit v, string tag);
    @(negedge clk);
    oe_i[c] = v;
    push(tag, v ? K_ON : K_OFF, c, cur_half ? 4 : 2);
    drain();
  endtask

  // Driver: change the rate controls; expect a switch only if the mode moves.
  task automatic set_div2(bit pin, bit rb, string tag);
    bit nh;
    @(negedge clk);
    div2_pin_n = pin;
    div2_reg   = rb;
    nh = !pin || !rb;
    if (nh != cur_half) push(tag, nh ? K_HALF : K_FULL, 0, nh ? 4 : 2);
    cur_half = nh;
    drain();
    repeat (12) @(negedge clk);
  endtask

  task automatic high_width(int c, output int w);
    w = 0;
    while (clk_o[c] == 1'b1) @(negedge clk);
    while (clk_o[c] == 1'b0) @(negedge clk);
    while (clk_o[c] == 1'b1) begin w++; @(negedge clk); end
  endtask

  task automatic low_width(int c, output int w);
    w = 0;
    while (clk_o[c] == 1'b0) @(negedge clk);
    while (clk_o[c] == 1'b1) @(negedge clk);
    while (clk_o[c] == 1'b0) begin w++; @(negedge clk); end
  endtask

  task automatic strap_case(bit bp, bit br, bit wp, bit wr, string tag);
    @(negedge clk);
    bypass_pin_n = bp; bypass_reg = br; hibw_pin_n = wp; hibw_reg = wr;
    repeat (5) @(negedge clk);
    check_eq({"R7 bypass ", tag}, int'(bypass_o), int'(!bp || !br));
    check_eq({"R8 hibw ", tag}, int'(hibw_o), int'(!wp || !wr));
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0 (run hung)", cyc);
      report();
      $finish;
    end
  end

  initial begin
    int w;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    check_eq("R1 clk_o after reset", int'(clk_o), 0);
    check_eq("R1 drive_o after reset", int'(drive_o), 0);
    check_eq("R1 bypass_o after reset", int'(bypass_o), 0);
    check_eq("R1 hibw_o after reset", int'(hibw_o), 0);
    repeat (10) @(negedge clk);
    check_eq("R1 outputs stay idle", int'(clk_o | drive_o), 0);

    // R2: enable in full rate, R4 width
    set_oe(0, 1'b1, "R2 enable ch0 full");
    set_oe(2, 1'b1, "R2 enable ch2 full");
    set_oe(1, 1'b1, "R2 enable ch1 full");
    high_width(0, w); check_eq("R4 full high width", w, 1);
    low_width(0, w);  check_eq("R4 full low width", w, 1);

    // R5: switch to half via pin, R4 widths
    chk_together = 1;
    set_div2(1'b0, 1'b1, "R5 pin to half");
    high_width(0, w); check_eq("R4 half high width", w, 2);
    low_width(2, w);  check_eq("R4 half low width", w, 2);
    chk_together = 0;

    // R2 and R3 in half rate
    set_oe(3, 1'b1, "R2 enable ch3 half");
    set_oe(1, 1'b0, "R3 disable ch1 half");
    check_eq("R3 ch1 parked low", int'(clk_o[1]), 0);

    // R5: OR of pin and register bit
    chk_together = 1;
    set_div2(1'b0, 1'b0, "R5 both low stays half");
    set_div2(1'b1, 1'b0, "R5 reg alone keeps half");
    high_width(0, w); check_eq("R5 reg bit alone gives half", w, 2);
    set_div2(1'b1, 1'b1, "R5 back to full");
    high_width(3, w); check_eq("R5 full after release", w, 1);
    chk_together = 0;

    // R3 in full rate
    set_oe(0, 1'b0, "R3 disable ch0 full");
    set_oe(2, 1'b0, "R3 disable ch2 full");
    repeat (8) @(negedge clk);
    check_eq("R3 parked outputs low", int'(clk_o & 4'b0111), 0);
    check_eq("R3 parked drivers off", int'(drive_o), 4'b1000);

    // R7 / R8 combinations
    strap_case(1'b0, 1'b1, 1'b1, 1'b0, "pin/reg");
    strap_case(1'b1, 1'b0, 1'b0, 1'b1, "reg/pin");
    strap_case(1'b0, 1'b0, 1'b0, 1'b0, "both low");
    strap_case(1'b1, 1'b1, 1'b1, 1'b1, "both high");

    // R6 / R3 / R5 accumulated over the run
    check_eq("R6 high phases of width 1 or 2", bad_phase, 0);
    check_eq("R3 output high while not driven", bad_off, 0);
    check_eq("R5 enabled outputs switch together", bad_sync, 0);
    check_eq("R2 R3 R5 no unmatched events", q.size(), 0);

    done = 1;
    report();
    $finish;
  end
endmodule